// File: doc/BRIEF.md
# Bank-Interleaved DRAM Command Sequencer

This block turns a stream of two-column transactions into commands for one multi-bank DRAM device. It drives a row channel and a column channel. Each accepted transaction produces one activate on the row channel, which carries the bank and row. A fixed time later it produces two column commands that carry the bank and one column address each. The last column command of a transaction also closes the bank. A write does this with an auto-precharge variant of its column command. A read does it with a precharge flag in the extended field of its second column slot.

Throughput comes from overlap. A transaction to a free, non-adjacent bank can start one row-to-row interval after the previous one, not one bank cycle after it. With the default timing, four transactions are in flight, and a steady stream rotating through banks B, B+2, B+4, B+6 keeps the column channel busy in every slot. The sequencer holds a transaction back (ready low) in four cases: the row-to-row spacing has not elapsed, its bank is within its bank cycle, a neighbouring bank is still open, or a write follows a read before the turnaround bubble has passed. Write data timing is marked by a strobe a fixed delay after every write column command.

Top module: `ileave_cmd_seq`

## Requirements
- R1: During and right after reset, row_valid, col_valid and wdata_go are low, and in_ready is high while idle.
- R2: An accepted transaction shows up as an activate (row_valid, row_bank, row_addr equal to its bank and row) in the cycle after the handshake edge, and transactions keep their order.
- R3: Two activates are never closer than T_RR cycles. Back-to-back writes, or back-to-back reads, to free, non-adjacent banks are spaced exactly T_RR.
- R4: Two activates to the same bank are never closer than T_RC cycles. A rotation over four banks two apart reuses the first bank at exactly T_RC.
- R5: With ADJ_STALL=1, an activate to bank b comes only after bank b-1 and bank b+1 have issued their closing column command. When the previous transaction went to a neighbour, the gap is T_RCD+T_RR/2+1 cycles.
- R6: The first column command comes T_RCD cycles after its activate and the second comes T_RR/2 cycles after the first. Both carry the transaction's bank, with col_addr equal to col1 and then col2.
- R7: Write column commands use col_op 1 (write) first and col_op 2 (write with auto-precharge) second. Both have col_mask_valid=1 and col_pre=0.
- R8: Read column commands use col_op 0 both times with col_mask_valid=0. col_pre is 0 on the first and 1 on the second.
- R9: A write that directly follows a read activates T_RR+T_BUB cycles after it. The column gap from the read's last command to the write's first is at least T_RR/2+T_BUB. A read after a write gets no extra gap.
- R10: wdata_go pulses exactly T_CWD cycles after each write column command and at no other time.
- R11: In a steady same-type stream over rotating non-adjacent banks, consecutive column commands are exactly T_RR/2 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Transaction offered |
| in_ready | output | 1 | Transaction can be taken this cycle (depends on in_wr and in_bank) |
| in_wr | input | 1 | 1 = write, 0 = read |
| in_bank | input | BANK_W | Target bank |
| in_row | input | ROW_W | Row address |
| in_col1 | input | COL_W | First column address |
| in_col2 | input | COL_W | Second column address |
| row_valid | output | 1 | Activate on the row channel |
| row_bank | output | BANK_W | Activate bank |
| row_addr | output | ROW_W | Activate row |
| col_valid | output | 1 | Column command valid |
| col_op | output | 2 | 0 read, 1 write, 2 write with auto-precharge |
| col_bank | output | BANK_W | Column command bank |
| col_addr | output | COL_W | Column address |
| col_mask_valid | output | 1 | Byte-mask field present in this slot |
| col_pre | output | 1 | Precharge of col_bank in the extended field |
| wdata_go | output | 1 | Write data slot for the command T_CWD cycles earlier |

## Verification
Errors in the per-bank counters or open flags show up at the row channel. A counter that clears early lets an activate arrive inside T_RC or next to an open bank. A counter that clears late shows up as an activate later than the spacing the bench computes for a directed pair. Either way it is visible within one bank cycle of the offending transaction. A slip in the column delay line shows as a column command in the wrong cycle, or with the wrong op, bank or precharge flag, T_RCD to T_RCD+T_RR/2 cycles after its activate. A stale read/write history shows as a missing or spurious bubble on the very next activate.

// File: rtl/ileave_pkg.sv
package ileave_pkg;

   typedef enum logic [1:0] {
      COL_RD  = 2'd0,
      COL_WR  = 2'd1,
      COL_WRA = 2'd2
   } col_op_t;

   function automatic int cnt_w(input int unsigned maxval);
      return (maxval < 2) ? 1 : $clog2(maxval + 1);
   endfunction

endpackage

// File: rtl/txn_admit.sv
module txn_admit
   import ileave_pkg::*;
#(
   parameter int BANK_W = 4,
   parameter int ROW_W  = 9,
   parameter int T_RR   = 8,
   parameter int T_BUB  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_wr,
   input  logic [BANK_W-1:0] in_bank,
   input  logic [ROW_W-1:0]  in_row,
   input  logic              bank_blocked,
   output logic              in_ready,
   output logic              fire,
   output logic              row_valid,
   output logic [BANK_W-1:0] row_bank,
   output logic [ROW_W-1:0]  row_addr
);

   localparam int CW = cnt_w(T_RR + T_BUB);
   localparam logic [CW-1:0] GAP_LD = CW'(T_RR - 1);
   localparam logic [CW-1:0] TURN_LD = CW'(T_RR + T_BUB - 1);

   logic [CW-1:0] gap_cnt;
   logic [CW-1:0] turn_cnt;
   logic          last_rd;
   logic          turn_hold;

   assign turn_hold = last_rd && in_wr && (turn_cnt != '0);
   assign in_ready  = (gap_cnt == '0) && !turn_hold && !bank_blocked;
   assign fire      = in_valid && in_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_valid <= 1'b0;
         row_bank  <= '0;
         row_addr  <= '0;
         gap_cnt   <= '0;
         turn_cnt  <= '0;
         last_rd   <= 1'b0;
      end else begin
         row_valid <= fire;
         if (fire) begin
            row_bank <= in_bank;
            row_addr <= in_row;
            gap_cnt  <= GAP_LD;
            turn_cnt <= TURN_LD;
            last_rd  <= !in_wr;
         end else begin
            if (gap_cnt != '0)  gap_cnt  <= gap_cnt - 1'b1;
            if (turn_cnt != '0) turn_cnt <= turn_cnt - 1'b1;
         end
      end
   end

endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
   import ileave_pkg::*;
#(
   parameter int BANK_W    = 4,
   parameter int T_RC      = 32,
   parameter bit ADJ_STALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_en,
   input  logic [BANK_W-1:0] act_bank,
   input  logic              close_en,
   input  logic [BANK_W-1:0] close_bank,
   input  logic [BANK_W-1:0] q_bank,
   output logic              q_blocked
);

   localparam int NBANK = 1 << BANK_W;
   localparam int RCW   = cnt_w(T_RC);
   localparam logic [RCW-1:0] RC_LD = RCW'(T_RC - 1);
   localparam logic [BANK_W-1:0] TOP_BANK = BANK_W'(NBANK - 1);

   logic [NBANK-1:0] busy;
   logic [NBANK-1:0] open_q;
   logic             adj_hit;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic [RCW-1:0] rc_cnt;
      logic           is_act;
      logic           is_close;

      assign is_act   = act_en && (act_bank == BANK_W'(b));
      assign is_close = close_en && (close_bank == BANK_W'(b));
      assign busy[b]  = (rc_cnt != '0);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            rc_cnt    <= '0;
            open_q[b] <= 1'b0;
         end else begin
            if (is_act)
               rc_cnt <= RC_LD;
            else if (rc_cnt != '0)
               rc_cnt <= rc_cnt - 1'b1;
            if (is_act)
               open_q[b] <= 1'b1;
            else if (is_close)
               open_q[b] <= 1'b0;
         end
      end
   end

   if (ADJ_STALL) begin : g_adj
      logic lo_hit;
      logic hi_hit;
      assign lo_hit  = (q_bank != '0) && open_q[BANK_W'(q_bank - 1'b1)];
      assign hi_hit  = (q_bank != TOP_BANK) && open_q[BANK_W'(q_bank + 1'b1)];
      assign adj_hit = lo_hit || hi_hit;
   end else begin : g_noadj
      assign adj_hit = 1'b0;
   end

   assign q_blocked = busy[q_bank] || adj_hit;

endmodule

// File: rtl/col_pipe.sv
module col_pipe
   import ileave_pkg::*;
#(
   parameter int BANK_W = 4,
   parameter int COL_W  = 6,
   parameter int T_RCD  = 7,
   parameter int HALF   = 4,
   parameter int T_CWD  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic              ld_wr,
   input  logic [BANK_W-1:0] ld_bank,
   input  logic [COL_W-1:0]  ld_c1,
   input  logic [COL_W-1:0]  ld_c2,
   output logic              col_valid,
   output logic [1:0]        col_op,
   output logic [BANK_W-1:0] col_bank,
   output logic [COL_W-1:0]  col_addr,
   output logic              col_mask_valid,
   output logic              col_pre,
   output logic              wdata_go,
   output logic              close_en,
   output logic [BANK_W-1:0] close_bank
);

   localparam int NSTG = T_RCD + HALF;
   localparam int TAP1 = T_RCD - 1;
   localparam int TAP2 = NSTG - 1;

   logic              s_v    [NSTG];
   logic              s_wr   [NSTG];
   logic [BANK_W-1:0] s_bank [NSTG];
   logic [COL_W-1:0]  s_c1   [NSTG];
   logic [COL_W-1:0]  s_c2   [NSTG];

   logic       t1;
   logic       t2;
   logic       wr_issue;
   logic [T_CWD:0] wd_sr;

   assign t1         = s_v[TAP1];
   assign t2         = s_v[TAP2];
   assign close_en   = t2;
   assign close_bank = s_bank[TAP2];
   assign wr_issue   = (t2 && s_wr[TAP2]) || (t1 && s_wr[TAP1]);
   assign wdata_go   = wd_sr[T_CWD];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NSTG; i++) begin
            s_v[i]    <= 1'b0;
            s_wr[i]   <= 1'b0;
            s_bank[i] <= '0;
            s_c1[i]   <= '0;
            s_c2[i]   <= '0;
         end
      end else begin
         s_v[0]    <= ld;
         s_wr[0]   <= ld_wr;
         s_bank[0] <= ld_bank;
         s_c1[0]   <= ld_c1;
         s_c2[0]   <= ld_c2;
         for (int i = 1; i < NSTG; i++) begin
            s_v[i]    <= s_v[i-1];
            s_wr[i]   <= s_wr[i-1];
            s_bank[i] <= s_bank[i-1];
            s_c1[i]   <= s_c1[i-1];
            s_c2[i]   <= s_c2[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col_valid      <= 1'b0;
         col_op         <= COL_RD;
         col_bank       <= '0;
         col_addr       <= '0;
         col_mask_valid <= 1'b0;
         col_pre        <= 1'b0;
      end else begin
         col_valid <= t1 || t2;
         if (t2) begin
            col_op         <= s_wr[TAP2] ? COL_WRA : COL_RD;
            col_bank       <= s_bank[TAP2];
            col_addr       <= s_c2[TAP2];
            col_mask_valid <= s_wr[TAP2];
            col_pre        <= !s_wr[TAP2];
         end else if (t1) begin
            col_op         <= s_wr[TAP1] ? COL_WR : COL_RD;
            col_bank       <= s_bank[TAP1];
            col_addr       <= s_c1[TAP1];
            col_mask_valid <= s_wr[TAP1];
            col_pre        <= 1'b0;
         end else begin
            col_op         <= COL_RD;
            col_mask_valid <= 1'b0;
            col_pre        <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         wd_sr <= '0;
      else
         wd_sr <= {wd_sr[T_CWD-1:0], wr_issue};
   end

endmodule

// File: rtl/ileave_cmd_seq.sv
module ileave_cmd_seq
   import ileave_pkg::*;
#(
   parameter int BANK_W    = 4,
   parameter int ROW_W     = 9,
   parameter int COL_W     = 6,
   parameter int T_RR      = 8,
   parameter int T_RC      = 32,
   parameter int T_RCD     = 7,
   parameter int T_CWD     = 6,
   parameter int T_BUB     = 4,
   parameter bit ADJ_STALL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              in_wr,
   input  logic [BANK_W-1:0] in_bank,
   input  logic [ROW_W-1:0]  in_row,
   input  logic [COL_W-1:0]  in_col1,
   input  logic [COL_W-1:0]  in_col2,
   output logic              row_valid,
   output logic [BANK_W-1:0] row_bank,
   output logic [ROW_W-1:0]  row_addr,
   output logic              col_valid,
   output logic [1:0]        col_op,
   output logic [BANK_W-1:0] col_bank,
   output logic [COL_W-1:0]  col_addr,
   output logic              col_mask_valid,
   output logic              col_pre,
   output logic              wdata_go
);

   localparam int HALF = T_RR / 2;

   if (T_RC != 4 * T_RR) begin : g_bad_rc
      $error("ileave_cmd_seq: T_RC must be four times T_RR");
   end
   if (T_RR < 2 || (T_RR % 2) != 0) begin : g_bad_rr
      $error("ileave_cmd_seq: T_RR must be even and at least 2");
   end
   if (T_RCD < 1 || T_CWD < 1 || T_BUB < 0) begin : g_bad_dly
      $error("ileave_cmd_seq: T_RCD and T_CWD must be at least 1, T_BUB non-negative");
   end
   if (BANK_W < 2 || ROW_W < 1 || COL_W < 1) begin : g_bad_w
      $error("ileave_cmd_seq: field widths out of range");
   end

   logic              fire;
   logic              blocked;
   logic              close_en;
   logic [BANK_W-1:0] close_bank;

   txn_admit #(
      .BANK_W (BANK_W),
      .ROW_W  (ROW_W),
      .T_RR   (T_RR),
      .T_BUB  (T_BUB)
   ) u_admit (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_wr        (in_wr),
      .in_bank      (in_bank),
      .in_row       (in_row),
      .bank_blocked (blocked),
      .in_ready     (in_ready),
      .fire         (fire),
      .row_valid    (row_valid),
      .row_bank     (row_bank),
      .row_addr     (row_addr)
   );

   bank_tracker #(
      .BANK_W    (BANK_W),
      .T_RC      (T_RC),
      .ADJ_STALL (ADJ_STALL)
   ) u_banks (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_en     (fire),
      .act_bank   (in_bank),
      .close_en   (close_en),
      .close_bank (close_bank),
      .q_bank     (in_bank),
      .q_blocked  (blocked)
   );

   col_pipe #(
      .BANK_W (BANK_W),
      .COL_W  (COL_W),
      .T_RCD  (T_RCD),
      .HALF   (HALF),
      .T_CWD  (T_CWD)
   ) u_cols (
      .clk            (clk),
      .rst_n          (rst_n),
      .ld             (fire),
      .ld_wr          (in_wr),
      .ld_bank        (in_bank),
      .ld_c1          (in_col1),
      .ld_c2          (in_col2),
      .col_valid      (col_valid),
      .col_op         (col_op),
      .col_bank       (col_bank),
      .col_addr       (col_addr),
      .col_mask_valid (col_mask_valid),
      .col_pre        (col_pre),
      .wdata_go       (wdata_go),
      .close_en       (close_en),
      .close_bank     (close_bank)
   );

endmodule

// File: rtl/ileave_cmd_seq_chk.sv
module ileave_cmd_seq_chk #(
   parameter int BANK_W    = 4,
   parameter int T_RR      = 8,
   parameter int T_RC      = 32,
   parameter int T_BUB     = 4,
   parameter bit ADJ_STALL = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              row_valid,
   input logic [BANK_W-1:0] row_bank,
   input logic              col_valid,
   input logic [1:0]        col_op,
   input logic [BANK_W-1:0] col_bank,
   input logic              col_mask_valid,
   input logic              col_pre,
   input logic              wdata_go
);

   localparam int NBANK = 1 << BANK_W;
   localparam logic [BANK_W-1:0] TOP_BANK = BANK_W'(NBANK - 1);

   logic [15:0]      since_act;
   logic             have_act;
   logic [15:0]      bank_since [NBANK];
   logic [NBANK-1:0] bank_have;
   logic [NBANK-1:0] open_c;
   logic [15:0]      since_col;
   logic             have_col;
   logic             last_col_rd;
   logic             closing;

   assign closing = col_valid && (col_pre || col_op == 2'd2);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_act   <= '0;
         have_act    <= 1'b0;
         since_col   <= '0;
         have_col    <= 1'b0;
         last_col_rd <= 1'b0;
         bank_have   <= '0;
         open_c      <= '0;
         for (int b = 0; b < NBANK; b++) bank_since[b] <= '0;
      end else begin
         since_act <= row_valid ? 16'd1 : ((since_act == 16'hFFFF) ? since_act : since_act + 16'd1);
         if (row_valid) have_act <= 1'b1;
         since_col <= col_valid ? 16'd1 : ((since_col == 16'hFFFF) ? since_col : since_col + 16'd1);
         if (col_valid) begin
            have_col    <= 1'b1;
            last_col_rd <= (col_op == 2'd0);
         end
         for (int b = 0; b < NBANK; b++) begin
            if (row_valid && row_bank == BANK_W'(b)) begin
               bank_since[b] <= 16'd1;
               bank_have[b]  <= 1'b1;
               open_c[b]     <= 1'b1;
            end else begin
               if (bank_since[b] != 16'hFFFF) bank_since[b] <= bank_since[b] + 16'd1;
               if (closing && col_bank == BANK_W'(b)) open_c[b] <= 1'b0;
            end
         end
      end
   end

   a_r1_reset_idle: assert property (@(posedge clk)
      $rose(rst_n) |-> (!row_valid && !col_valid && !wdata_go));

   a_r3_rr_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid && have_act) |-> (since_act >= 16'(T_RR)));

   a_r4_rc_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (row_valid && bank_have[row_bank]) |-> (bank_since[row_bank] >= 16'(T_RC)));

   a_r5_adj_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (ADJ_STALL && row_valid && row_bank != '0) |-> !open_c[BANK_W'(row_bank - 1'b1)]);

   a_r5_adj_hi: assert property (@(posedge clk) disable iff (!rst_n)
      (ADJ_STALL && row_valid && row_bank != TOP_BANK) |-> !open_c[BANK_W'(row_bank + 1'b1)]);

   a_r6_col_bank_open: assert property (@(posedge clk) disable iff (!rst_n)
      col_valid |-> open_c[col_bank]);

   a_r7_wr_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && col_op != 2'd0) |-> (col_mask_valid && !col_pre && col_op != 2'd3));

   a_r8_rd_nomask: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && col_op == 2'd0) |-> !col_mask_valid);

   a_r9_turn_bubble: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && col_op != 2'd0 && have_col && last_col_rd) |-> (since_col >= 16'(T_RR / 2 + T_BUB)));

endmodule

bind ileave_cmd_seq ileave_cmd_seq_chk #(
   .BANK_W    (BANK_W),
   .T_RR      (T_RR),
   .T_RC      (T_RC),
   .T_BUB     (T_BUB),
   .ADJ_STALL (ADJ_STALL)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .row_valid      (row_valid),
   .row_bank       (row_bank),
   .col_valid      (col_valid),
   .col_op         (col_op),
   .col_bank       (col_bank),
   .col_mask_valid (col_mask_valid),
   .col_pre        (col_pre),
   .wdata_go       (wdata_go)
);

// File: tb/test_ileave_cmd_seq.sv
`timescale 1ns/1ps
module test_ileave_cmd_seq;

   localparam int BANK_W = 4;
   localparam int ROW_W  = 9;
   localparam int COL_W  = 6;
   localparam int T_RR   = 8;
   localparam int T_RC   = 32;
   localparam int T_RCD  = 7;
   localparam int T_CWD  = 6;
   localparam int T_BUB  = 4;
   localparam int HALF   = T_RR / 2;
   localparam int NSTG   = T_RCD + HALF;
   localparam int NBANK  = 1 << BANK_W;

   typedef struct packed {
      logic              wr;
      logic [BANK_W-1:0] bank;
      logic [ROW_W-1:0]  row;
      logic [COL_W-1:0]  c1;
      logic [COL_W-1:0]  c2;
   } txn_t;

   typedef struct packed {
      logic              wr;
      logic              second;
      logic [BANK_W-1:0] bank;
      logic [COL_W-1:0]  col;
   } ecol_t;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              in_valid;
   logic              in_ready;
   logic              in_wr;
   logic [BANK_W-1:0] in_bank;
   logic [ROW_W-1:0]  in_row;
   logic [COL_W-1:0]  in_col1;
   logic [COL_W-1:0]  in_col2;
   logic              row_valid;
   logic [BANK_W-1:0] row_bank;
   logic [ROW_W-1:0]  row_addr;
   logic              col_valid;
   logic [1:0]        col_op;
   logic [BANK_W-1:0] col_bank;
   logic [COL_W-1:0]  col_addr;
   logic              col_mask_valid;
   logic              col_pre;
   logic              wdata_go;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   txn_t  txq[$];
   int    dueq[$];
   ecol_t exp_col[int];
   bit    exp_wd[int];
   int    act_log[$];
   int    col_log[$];
   int    last_act[NBANK];
   int    last_any = -1;
   int    last_col_cyc = -1;
   bit    last_col_rd = 1'b0;

   bit sc_wr[16];
   int sc_bank[16];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   ileave_cmd_seq i_ileave_cmd_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .in_valid       (in_valid),
      .in_ready       (in_ready),
      .in_wr          (in_wr),
      .in_bank        (in_bank),
      .in_row         (in_row),
      .in_col1        (in_col1),
      .in_col2        (in_col2),
      .row_valid      (row_valid),
      .row_bank       (row_bank),
      .row_addr       (row_addr),
      .col_valid      (col_valid),
      .col_op         (col_op),
      .col_bank       (col_bank),
      .col_addr       (col_addr),
      .col_mask_valid (col_mask_valid),
      .col_pre        (col_pre),
      .wdata_go       (wdata_go)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   function automatic int exp_op(input bit wr, input bit second);
      if (!wr) return 0;
      return second ? 2 : 1;
   endfunction

   function automatic int exp_act_gap(input bit pw, input bit cw, input int pb, input int cb);
      int g;
      g = T_RR;
      if (!pw && cw) g = T_RR + T_BUB;
      if (pb == cb && g < T_RC) g = T_RC;
      if ((pb - cb == 1 || cb - pb == 1) && g < NSTG + 1) g = NSTG + 1;
      return g;
   endfunction

   // monitor: every output checked against the bench's own schedule
   always @(negedge clk) begin
      if (rst_n) begin
         if (in_valid && in_ready) begin
            txq.push_back({in_wr, in_bank, in_row, in_col1, in_col2});
            dueq.push_back(cyc + 1);
         end
         if (row_valid) begin
            if (txq.size() == 0) begin
               chk(1'b0, "R2", "activate without transaction", 1, 0);
            end else begin
               txn_t t;
               int due;
               int b;
               t = txq.pop_front();
               due = dueq.pop_front();
               b = int'(t.bank);
               chk(due == cyc, "R2", "activate cycle", cyc, due);
               chk(row_bank == t.bank, "R2", "activate bank", int'(row_bank), b);
               chk(row_addr == t.row, "R2", "activate row", int'(row_addr), int'(t.row));
               if (last_any >= 0)
                  chk(cyc - last_any >= T_RR, "R3", "activate spacing", cyc - last_any, T_RR);
               if (last_act[b] >= 0)
                  chk(cyc - last_act[b] >= T_RC, "R4", "same-bank spacing", cyc - last_act[b], T_RC);
               if (b > 0 && last_act[b-1] >= 0)
                  chk(cyc > last_act[b-1] + NSTG, "R5", "activate beside open lower bank", cyc, last_act[b-1] + NSTG + 1);
               if (b < NBANK - 1 && last_act[b+1] >= 0)
                  chk(cyc > last_act[b+1] + NSTG, "R5", "activate beside open upper bank", cyc, last_act[b+1] + NSTG + 1);
               last_any = cyc;
               last_act[b] = cyc;
               act_log.push_back(cyc);
               exp_col[cyc + T_RCD] = {t.wr, 1'b0, t.bank, t.c1};
               exp_col[cyc + NSTG]  = {t.wr, 1'b1, t.bank, t.c2};
            end
         end else if (dueq.size() > 0 && dueq[0] == cyc) begin
            chk(1'b0, "R2", "activate missing", 0, 1);
         end

         if (col_valid) begin
            if (!exp_col.exists(cyc)) begin
               chk(1'b0, "R6", "unexpected column command", 1, 0);
            end else begin
               ecol_t e;
               e = exp_col[cyc];
               exp_col.delete(cyc);
               chk(col_bank == e.bank, "R6", "column bank", int'(col_bank), int'(e.bank));
               chk(col_addr == e.col, "R6", "column address", int'(col_addr), int'(e.col));
               chk(int'(col_op) == exp_op(e.wr, e.second), e.wr ? "R7" : "R8", "column op",
                   int'(col_op), exp_op(e.wr, e.second));
               chk(col_mask_valid == e.wr, e.wr ? "R7" : "R8", "mask field", int'(col_mask_valid), int'(e.wr));
               chk(col_pre == (!e.wr && e.second), e.wr ? "R7" : "R8", "precharge flag",
                   int'(col_pre), int'(!e.wr && e.second));
               if (e.wr && last_col_rd && last_col_cyc >= 0)
                  chk(cyc - last_col_cyc >= HALF + T_BUB, "R9", "read-to-write column gap",
                      cyc - last_col_cyc, HALF + T_BUB);
               if (e.wr) exp_wd[cyc + T_CWD] = 1'b1;
               last_col_rd = !e.wr;
            end
            last_col_cyc = cyc;
            col_log.push_back(cyc);
         end else if (exp_col.exists(cyc)) begin
            chk(1'b0, "R6", "column command missing", 0, 1);
            exp_col.delete(cyc);
         end

         if (exp_wd.exists(cyc)) begin
            chk(wdata_go == 1'b1, "R10", "write data strobe", int'(wdata_go), 1);
            exp_wd.delete(cyc);
         end else if (wdata_go) begin
            chk(1'b0, "R10", "spurious write data strobe", 1, 0);
         end
      end
   end

   task automatic send(input bit wr, input int b, input int r, input int c1, input int c2);
      in_valid = 1'b1;
      in_wr    = wr;
      in_bank  = BANK_W'(b);
      in_row   = ROW_W'(r);
      in_col1  = COL_W'(c1);
      in_col2  = COL_W'(c2);
      do @(negedge clk); while (!in_ready);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic settle();
      repeat (T_RC + NSTG + T_CWD + 8) @(posedge clk);
      #1;
   endtask

   // plays sc_* back to back, then checks activate spacing against exp_act_gap
   task automatic play(input int n, input string req);
      int base;
      base = act_log.size();
      for (int i = 0; i < n; i++)
         send(sc_wr[i], sc_bank[i], 16 * i + 3, 2 * i + 1, 2 * i + 2);
      settle();
      chk(act_log.size() - base == n, req, "activate count", act_log.size() - base, n);
      if (act_log.size() - base == n) begin
         for (int i = 1; i < n; i++)
            chk(act_log[base+i] - act_log[base+i-1] ==
                exp_act_gap(sc_wr[i-1], sc_wr[i], sc_bank[i-1], sc_bank[i]),
                req, "directed activate gap", act_log[base+i] - act_log[base+i-1],
                exp_act_gap(sc_wr[i-1], sc_wr[i], sc_bank[i-1], sc_bank[i]));
      end
   endtask

   task automatic check_full_column(input int first, input int cnt);
      for (int i = first + 1; i < first + cnt; i++)
         chk(col_log[i] - col_log[i-1] == HALF, "R11", "column slot spacing", col_log[i] - col_log[i-1], HALF);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int cb;
      void'($urandom(32'h1F2E3D4C));
      for (int b = 0; b < NBANK; b++) last_act[b] = -1;
      rst_n = 1'b0;
      in_valid = 1'b0;
      in_wr = 1'b0;
      in_bank = '0;
      in_row = '0;
      in_col1 = '0;
      in_col2 = '0;
      repeat (3) @(negedge clk);
      chk(!row_valid && !col_valid && !wdata_go, "R1", "outputs in reset",
          int'({row_valid, col_valid, wdata_go}), 0);
      @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!row_valid && !col_valid && !wdata_go, "R1", "outputs after reset",
          int'({row_valid, col_valid, wdata_go}), 0);
      chk(in_ready == 1'b1, "R1", "ready when idle", int'(in_ready), 1);
      @(posedge clk);
      #1;

      // R3 R4 R11: write rotation, fifth reuses the first bank
      sc_wr = '{default: 1'b1};
      sc_bank[0] = 0; sc_bank[1] = 2; sc_bank[2] = 4; sc_bank[3] = 6;
      sc_bank[4] = 0; sc_bank[5] = 2;
      cb = col_log.size();
      play(6, "R3");
      chk(act_log[act_log.size()-2] - act_log[act_log.size()-6] == T_RC, "R4",
          "fifth transaction bank reuse", act_log[act_log.size()-2] - act_log[act_log.size()-6], T_RC);
      check_full_column(cb, 12);

      // R8 R11: read rotation
      sc_wr = '{default: 1'b0};
      sc_bank[0] = 8; sc_bank[1] = 10; sc_bank[2] = 12; sc_bank[3] = 14; sc_bank[4] = 8;
      cb = col_log.size();
      play(5, "R8");
      check_full_column(cb, 10);

      // R9: read, write (bubble), read (no bubble), write (bubble)
      sc_wr[0] = 1'b0; sc_bank[0] = 0;
      sc_wr[1] = 1'b1; sc_bank[1] = 4;
      sc_wr[2] = 1'b0; sc_bank[2] = 8;
      sc_wr[3] = 1'b1; sc_bank[3] = 12;
      cb = col_log.size();
      play(4, "R9");
      chk(col_log[cb+2] - col_log[cb+1] == HALF + T_BUB, "R9", "bubble on column channel",
          col_log[cb+2] - col_log[cb+1], HALF + T_BUB);

      // R4: same bank twice
      sc_wr[0] = 1'b1; sc_bank[0] = 3;
      sc_wr[1] = 1'b1; sc_bank[1] = 3;
      play(2, "R4");

      // R5: neighbour bank waits for the close
      sc_wr[0] = 1'b0; sc_bank[0] = 5;
      sc_wr[1] = 1'b1; sc_bank[1] = 6;
      sc_wr[2] = 1'b1; sc_bank[2] = 7;
      play(3, "R5");

      // R10 R6: single isolated write
      sc_wr[0] = 1'b1; sc_bank[0] = 15;
      play(1, "R10");

      // random mix, rules checked by the monitor
      for (int i = 0; i < 200; i++) begin
         send(1'($urandom % 2), int'($urandom % NBANK), int'($urandom % (1 << ROW_W)),
              int'($urandom % (1 << COL_W)), int'($urandom % (1 << COL_W)));
         if ($urandom % 4 == 0) begin
            repeat ($urandom % 6) @(posedge clk);
            #1;
         end
      end
      settle();
      chk(txq.size() == 0, "R2", "transactions left unissued", txq.size(), 0);
      chk(exp_col.size() == 0, "R6", "column commands left unissued", exp_col.size(), 0);
      chk(exp_wd.size() == 0, "R10", "write strobes left unissued", exp_wd.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule